// File: doc/BRIEF.md
# Access-Code and Pointer Protection Controller

This block decides, address by address, whether a read or a program/erase operation on a serial non-volatile array may go ahead. It holds a variable-length access code (0 to `MAX_BYTES` bytes), a movable boundary pointer that splits the array into a lower and an upper part, and a small set of enable flags: program/erase enabled, access unlocked, access disabled, and a single-use override. Stand-in registers with reset defaults hold the code and pointer.

A command decoder upstream feeds the block one strobe per decoded command, with byte payloads arriving one strobe at a time. A zero-length code selects the unprotected mode. In that mode the pointer only guards the lower part against program/erase. A non-zero length selects the secure mode. In secure mode the upper part is read-only and the lower part is closed until the stored code is presented. The array sequencer queries `rd_ok_o` and `wr_ok_o` combinationally for the address it is about to touch, and it reports the end of each program/erase on `op_done_i`.

Top module: `prot_guard`

## Requirements
- R1: After reset the code length is 0, the pointer is 0, and program/erase, unlock, disable and override are all clear. `rd_ok_o` is 1 for every address. `wr_ok_o` is 0 until program/erase is enabled, and is then 1 for every address.
- R2: In unprotected mode (length 0), reads are permitted at every address. A program/erase at an address at or above the pointer is permitted. A program/erase below the pointer is refused unless the override is set.
- R3: In secure mode (length 1..`MAX_BYTES`), an address at or above the pointer is readable and never writable. An address below the pointer is neither readable nor writable until access has been unlocked, and is then readable and writable.
- R4: Set-code (`cmd_i`=1) takes a length byte, then the stored code (only if the stored length is non-zero), then the new code twice. The new code and length take effect after the last byte, and only if every old byte matched and both copies agree. Otherwise nothing changes.
- R5: A set-code length of 0 returns the block to unprotected mode. A length above `MAX_BYTES` causes every later payload byte to be ignored until the next command.
- R6: Override (`cmd_i`=5) permits program/erase below the pointer until the next `op_done_i`, which clears it. If override and `op_done_i` arrive in the same cycle, the override ends up clear.
- R7: In secure mode without unlocked access, write-pointer (`cmd_i`=4) and override are ignored.
- R8: Disable-access (`cmd_i`=3) drops the unlock and forces `wr_ok_o` to 0 at every address until a successful unlock (`cmd_i`=2). With length 0, an unlock succeeds as soon as the command is taken.
- R9: An all-array operation (`all_i`=1) ignores the pointer. It is permitted in unprotected mode, and in secure mode only with access unlocked, subject to R8 and R10.
- R10: Program/erase enable (`cmd_i`=6) stays set until program/erase disable (`cmd_i`=7). `wr_ok_o` is 0 whenever it is clear. `abort_i` changes neither it nor the unlock.
- R11: `abort_i`, or any command other than the one being collected, abandons a partly received payload with no change to the code. Bytes that arrive with no collection open have no effect.
- R12: Unlock compares one byte per strobe against the stored code and grants access only after the last of the stored-length bytes. A wrong byte anywhere in that run refuses the unlock.
- R13: `ptr_o` shows the pointer. Write-pointer loads it from `addr_i` when permitted, and nothing else changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on defaults) |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command: 0 none, 1 set-code, 2 unlock, 3 disable, 4 write-pointer, 5 override, 6 PE on, 7 PE off |
| byte_valid_i | input | 1 | Payload byte strobe |
| byte_i | input | 8 | Payload byte |
| abort_i | input | 1 | Abandon payload collection (chip-select reset) |
| op_done_i | input | 1 | A program/erase operation completed |
| addr_i | input | ADDR_W | Query address; pointer value for write-pointer |
| all_i | input | 1 | Query is for an all-array operation |
| rd_ok_o | output | 1 | Read permitted at `addr_i` |
| wr_ok_o | output | 1 | Program/erase permitted at `addr_i` |
| ptr_o | output | ADDR_W | Current pointer |

## Verification
Two events can land on the same clock edge: an override being set and an `op_done_i` retiring the previous operation. If the set wins, one override silently covers two operations. The bench drives both strobes in one cycle and then sweeps every address below the pointer, expecting the writes refused. It also sweeps all addresses, for both `all_i` values, after every state change. These sweeps are compared with permissions computed from a small bench model that follows the requirements.

// File: rtl/prot_pkg.sv
package prot_pkg;

  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_SET_CODE    = 3'd1,
    CMD_UNLOCK      = 3'd2,
    CMD_DISABLE_ACC = 3'd3,
    CMD_WRITE_PTR   = 3'd4,
    CMD_OVERRIDE    = 3'd5,
    CMD_PE_ON       = 3'd6,
    CMD_PE_OFF      = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LEN,
    PH_OLD,
    PH_NEW1,
    PH_NEW2,
    PH_DRAIN,
    PH_UNLOCK
  } phase_e;

endpackage

// File: rtl/prot_code_unit.sv
module prot_code_unit
  import prot_pkg::*;
#(
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4,
  parameter int IDX_W     = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cancel_i,
  input  logic             start_set_i,
  input  logic             start_unlock_i,
  input  logic             other_cmd_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_i,
  output logic [LEN_W-1:0] code_len_o,
  output logic             unlock_ok_o
);

  phase_e           phase_q;
  logic [LEN_W-1:0] idx_q, new_len_q, code_len_q;
  logic             mis_q;
  logic [7:0]       code_q   [MAX_BYTES];
  logic [7:0]       shadow_q [MAX_BYTES];

  logic             take;
  logic [LEN_W-1:0] idx_inc, phase_len;
  logic             last, mis_n, len_big;
  logic [IDX_W-1:0] ix;
  logic [7:0]       ref_byte;

  // A byte counts only when no command or abort shares its cycle
  assign take      = byte_valid_i & ~cancel_i & ~start_set_i & ~start_unlock_i & ~other_cmd_i;
  assign idx_inc   = idx_q + LEN_W'(1);
  assign phase_len = (phase_q == PH_NEW1 || phase_q == PH_NEW2) ? new_len_q : code_len_q;
  assign last      = (idx_inc == phase_len);
  assign ix        = idx_q[IDX_W-1:0];
  assign ref_byte  = (phase_q == PH_NEW2) ? shadow_q[ix] : code_q[ix];
  assign mis_n     = mis_q | (byte_i != ref_byte);
  assign len_big   = ({24'd0, byte_i} > 32'(MAX_BYTES));

  assign unlock_ok_o = (start_unlock_i & ~cancel_i & (code_len_q == '0))
                     | (take & (phase_q == PH_UNLOCK) & last & ~mis_n);
  assign code_len_o  = code_len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      idx_q      <= '0;
      new_len_q  <= '0;
      code_len_q <= '0;
      mis_q      <= 1'b0;
      for (int i = 0; i < MAX_BYTES; i++) begin
        code_q[i]   <= '0;
        shadow_q[i] <= '0;
      end
    end else if (cancel_i) begin
      phase_q <= PH_IDLE;
    end else if (start_set_i) begin
      phase_q <= PH_LEN;
      idx_q   <= '0;
      mis_q   <= 1'b0;
    end else if (start_unlock_i) begin
      phase_q <= (code_len_q == '0) ? PH_IDLE : PH_UNLOCK;
      idx_q   <= '0;
      mis_q   <= 1'b0;
    end else if (other_cmd_i) begin
      phase_q <= PH_IDLE;
    end else if (take) begin
      unique case (phase_q)
        PH_LEN: begin
          idx_q <= '0;
          if (len_big) begin
            phase_q <= PH_DRAIN;
          end else begin
            new_len_q <= byte_i[LEN_W-1:0];
            if (code_len_q != '0)   phase_q <= PH_OLD;
            else if (byte_i != '0)  phase_q <= PH_NEW1;
            else                    phase_q <= PH_IDLE;
          end
        end
        PH_OLD: begin
          mis_q <= mis_n;
          idx_q <= idx_inc;
          if (last) begin
            idx_q <= '0;
            if (new_len_q != '0) begin
              phase_q <= PH_NEW1;
            end else begin
              phase_q <= PH_IDLE;
              if (!mis_n) code_len_q <= '0;
            end
          end
        end
        PH_NEW1: begin
          shadow_q[ix] <= byte_i;
          idx_q        <= idx_inc;
          if (last) begin
            idx_q   <= '0;
            phase_q <= PH_NEW2;
          end
        end
        PH_NEW2: begin
          mis_q <= mis_n;
          idx_q <= idx_inc;
          if (last) begin
            phase_q <= PH_IDLE;
            if (!mis_n) begin
              code_len_q <= new_len_q;
              code_q     <= shadow_q;
            end
          end
        end
        PH_UNLOCK: begin
          mis_q <= mis_n;
          idx_q <= idx_inc;
          if (last) phase_q <= PH_IDLE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/prot_flag_unit.sv
module prot_flag_unit #(
  parameter int ADDR_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              secure_i,
  input  logic              pe_on_i,
  input  logic              pe_off_i,
  input  logic              disable_i,
  input  logic              unlock_ok_i,
  input  logic              wr_ptr_i,
  input  logic [ADDR_W-1:0] ptr_val_i,
  input  logic              set_ovr_i,
  input  logic              op_done_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              pe_en_o,
  output logic              acc_en_o,
  output logic              locked_o,
  output logic              ovr_o
);

  logic priv;
  assign priv = ~secure_i | acc_en_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_o    <= '0;
      pe_en_o  <= 1'b0;
      acc_en_o <= 1'b0;
      locked_o <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      if (pe_on_i)       pe_en_o <= 1'b1;
      else if (pe_off_i) pe_en_o <= 1'b0;

      if (disable_i) begin
        acc_en_o <= 1'b0;
        locked_o <= 1'b1;
      end else if (unlock_ok_i) begin
        acc_en_o <= 1'b1;
        locked_o <= 1'b0;
      end

      if (wr_ptr_i && priv) ptr_o <= ptr_val_i;

      // completion beats a fresh set: one override never spans two operations
      if (op_done_i)              ovr_o <= 1'b0;
      else if (set_ovr_i && priv) ovr_o <= 1'b1;
    end
  end

endmodule

// File: rtl/prot_permit.sv
module prot_permit #(
  parameter int ADDR_W = 9
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              all_i,
  input  logic [ADDR_W-1:0] ptr_i,
  input  logic              secure_i,
  input  logic              pe_en_i,
  input  logic              acc_en_i,
  input  logic              locked_i,
  input  logic              ovr_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o
);

  logic below, addr_ok;

  assign below = (addr_i < ptr_i);

  always_comb begin
    if (all_i)         addr_ok = ~secure_i | acc_en_i;
    else if (secure_i) addr_ok = below & acc_en_i;
    else               addr_ok = ~below | ovr_i;
  end

  assign rd_ok_o = ~secure_i | ~below | acc_en_i;
  assign wr_ok_o = pe_en_i & ~locked_i & addr_ok;

endmodule

// File: rtl/prot_guard.sv
module prot_guard
  import prot_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int MAX_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              abort_i,
  input  logic              op_done_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              all_i,
  output logic              rd_ok_o,
  output logic              wr_ok_o,
  output logic [ADDR_W-1:0] ptr_o
);

  localparam int LEN_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

  cmd_e             cmd;
  logic             c_set, c_unlock, c_dis, c_ptr, c_ovr, c_pe_on, c_pe_off, c_other;
  logic [LEN_W-1:0] code_len;
  logic             unlock_ok, secure, pe_en, acc_en, locked, ovr;

  assign cmd      = cmd_e'(cmd_i);
  assign c_set    = cmd_valid_i & (cmd == CMD_SET_CODE);
  assign c_unlock = cmd_valid_i & (cmd == CMD_UNLOCK);
  assign c_dis    = cmd_valid_i & (cmd == CMD_DISABLE_ACC);
  assign c_ptr    = cmd_valid_i & (cmd == CMD_WRITE_PTR);
  assign c_ovr    = cmd_valid_i & (cmd == CMD_OVERRIDE);
  assign c_pe_on  = cmd_valid_i & (cmd == CMD_PE_ON);
  assign c_pe_off = cmd_valid_i & (cmd == CMD_PE_OFF);
  assign c_other  = cmd_valid_i & ~c_set & ~c_unlock;
  assign secure   = (code_len != '0);

  prot_code_unit #(
    .MAX_BYTES (MAX_BYTES),
    .LEN_W     (LEN_W),
    .IDX_W     (IDX_W)
  ) u_code (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .cancel_i       (abort_i),
    .start_set_i    (c_set),
    .start_unlock_i (c_unlock),
    .other_cmd_i    (c_other),
    .byte_valid_i   (byte_valid_i),
    .byte_i         (byte_i),
    .code_len_o     (code_len),
    .unlock_ok_o    (unlock_ok)
  );

  prot_flag_unit #(
    .ADDR_W (ADDR_W)
  ) u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .secure_i    (secure),
    .pe_on_i     (c_pe_on),
    .pe_off_i    (c_pe_off),
    .disable_i   (c_dis),
    .unlock_ok_i (unlock_ok),
    .wr_ptr_i    (c_ptr),
    .ptr_val_i   (addr_i),
    .set_ovr_i   (c_ovr),
    .op_done_i   (op_done_i),
    .ptr_o       (ptr_o),
    .pe_en_o     (pe_en),
    .acc_en_o    (acc_en),
    .locked_o    (locked),
    .ovr_o       (ovr)
  );

  prot_permit #(
    .ADDR_W (ADDR_W)
  ) u_permit (
    .addr_i   (addr_i),
    .all_i    (all_i),
    .ptr_i    (ptr_o),
    .secure_i (secure),
    .pe_en_i  (pe_en),
    .acc_en_i (acc_en),
    .locked_i (locked),
    .ovr_i    (ovr),
    .rd_ok_o  (rd_ok_o),
    .wr_ok_o  (wr_ok_o)
  );

endmodule

// File: rtl/prot_guard_chk.sv
module prot_guard_chk #(
  parameter int ADDR_W    = 9,
  parameter int MAX_BYTES = 8,
  parameter int LEN_W     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [2:0]        cmd_i,
  input logic              abort_i,
  input logic              op_done_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              all_i,
  input logic              rd_ok_o,
  input logic              wr_ok_o,
  input logic [ADDR_W-1:0] ptr_o,
  input logic [LEN_W-1:0]  code_len,
  input logic              secure,
  input logic              pe_en,
  input logic              acc_en,
  input logic              locked,
  input logic              ovr
);

  p_rd_open_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !secure |-> rd_ok_o);

  p_sec_upper_ro_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure && !all_i && addr_i >= ptr_o) |-> !wr_ok_o);

  p_len_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(code_len) <= MAX_BYTES);

  p_ovr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_done_i |=> !ovr);

  p_sec_ptr_guard_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (secure && !acc_en && cmd_valid_i && cmd_i == 3'd4) |=> $stable(ptr_o));

  p_lock_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> !wr_ok_o);

  p_wr_needs_pe_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ok_o |-> pe_en);

  p_abort_keeps_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !cmd_valid_i) |=> ($stable(code_len) && $stable(acc_en) && $stable(pe_en)));

  p_ptr_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_i && cmd_i == 3'd4) |=> $stable(ptr_o));

endmodule

bind prot_guard prot_guard_chk #(
  .ADDR_W    (ADDR_W),
  .MAX_BYTES (MAX_BYTES),
  .LEN_W     (LEN_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .abort_i     (abort_i),
  .op_done_i   (op_done_i),
  .addr_i      (addr_i),
  .all_i       (all_i),
  .rd_ok_o     (rd_ok_o),
  .wr_ok_o     (wr_ok_o),
  .ptr_o       (ptr_o),
  .code_len    (code_len),
  .secure      (secure),
  .pe_en       (pe_en),
  .acc_en      (acc_en),
  .locked      (locked),
  .ovr         (ovr)
);

// File: tb/tb_prot_guard.sv
`timescale 1ns/1ps
module tb_prot_guard;

  localparam int AW = 4;
  localparam int NA = 1 << AW;
  localparam logic [2:0] K_SET = 3'd1, K_UNL = 3'd2, K_DIS = 3'd3, K_PTR = 3'd4,
                         K_OVR = 3'd5, K_PEON = 3'd6, K_PEOFF = 3'd7;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          cmd_valid = 1'b0, byte_valid = 1'b0, abort = 1'b0, op_done = 1'b0, all = 1'b0;
  logic [2:0]    cmd = '0;
  logic [7:0]    bval = '0;
  logic [AW-1:0] addr = '0;
  logic          rd_ok, wr_ok;
  logic [AW-1:0] ptr;

  int checks = 0, fails = 0;

  // bench model of the protection state
  int         m_len = 0, m_ptr = 0;
  logic [7:0] m_code [8];
  logic       m_pe = 0, m_acc = 0, m_lock = 0, m_ovr = 0;

  prot_guard #(.ADDR_W(AW), .MAX_BYTES(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .byte_valid_i(byte_valid), .byte_i(bval), .abort_i(abort), .op_done_i(op_done),
    .addr_i(addr), .all_i(all), .rd_ok_o(rd_ok), .wr_ok_o(wr_ok), .ptr_o(ptr)
  );

  always #10 clk = ~clk;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cmd(input logic [2:0] c, input int a = 0);
    @(negedge clk); cmd_valid = 1'b1; cmd = c; addr = AW'(a);
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); byte_valid = 1'b1; bval = b;
    @(negedge clk); byte_valid = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < NA; a++) begin
      for (int al = 0; al < 2; al++) begin
        logic sec, below, aok, erd, ewr;
        addr = AW'(a); all = al[0];
        #1;
        sec   = (m_len != 0);
        below = (a < m_ptr);
        erd   = !sec || !below || m_acc;
        if (al == 1)  aok = !sec || m_acc;
        else if (sec) aok = below && m_acc;
        else          aok = !below || m_ovr;
        ewr = m_pe && !m_lock && aok;
        check(rd_ok === erd, {req, " rd"}, int'(rd_ok), int'(erd));
        check(wr_ok === ewr, {req, " wr"}, int'(wr_ok), int'(ewr));
      end
    end
    all = 1'b0;
  endtask

  task automatic set_code(input int len, input logic [7:0] oc[8],
                          input logic [7:0] n1[8], input logic [7:0] n2[8]);
    int  ol = m_len;
    logic ok = 1'b1;
    do_cmd(K_SET);
    send_byte(8'(len));
    if (len <= 8) begin
      for (int i = 0; i < ol; i++)  send_byte(oc[i]);
      for (int i = 0; i < len; i++) send_byte(n1[i]);
      for (int i = 0; i < len; i++) send_byte(n2[i]);
      for (int i = 0; i < ol; i++)  if (oc[i] != m_code[i]) ok = 1'b0;
      for (int i = 0; i < len; i++) if (n1[i] != n2[i]) ok = 1'b0;
      if (ok) begin
        m_len = len;
        for (int i = 0; i < len; i++) m_code[i] = n1[i];
      end
    end else begin
      for (int i = 0; i < 6; i++) send_byte(n1[i]);
    end
  endtask

  task automatic unlock(input logic [7:0] c[8]);
    logic ok = 1'b1;
    do_cmd(K_UNL);
    for (int i = 0; i < m_len; i++) begin
      send_byte(c[i]);
      if (c[i] != m_code[i]) ok = 1'b0;
    end
    if (ok) begin m_acc = 1'b1; m_lock = 1'b0; end
  endtask

  task automatic sec_priv_ptr(input int a);
    do_cmd(K_PTR, a);
    if (m_len == 0 || m_acc) m_ptr = a;
  endtask

  logic [7:0] z8 [8]  = '{default: 8'h00};
  logic [7:0] ca [8]  = '{8'hA1, 8'hB2, 8'hC3, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] cbad[8] = '{8'hA1, 8'hB2, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] cb [8]  = '{8'h11, 8'h22, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] cb2[8]  = '{8'h11, 8'h23, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
  logic [7:0] c8 [8]  = '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h08};

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_code[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ptr === '0, "R1 ptr", int'(ptr), 0);
    sweep("R1 reset");
    do_cmd(K_PEON); m_pe = 1'b1;
    sweep("R1 R10 pe on");

    sec_priv_ptr(6);
    check(ptr === 4'd6, "R13 ptr", int'(ptr), 6);
    sweep("R2 unprot");

    do_cmd(K_OVR); m_ovr = 1'b1;
    sweep("R6 ovr set");
    @(negedge clk); op_done = 1'b1; @(negedge clk); op_done = 1'b0; m_ovr = 1'b0;
    sweep("R6 ovr cleared");
    // override and completion in one cycle
    @(negedge clk); cmd_valid = 1'b1; cmd = K_OVR; op_done = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; op_done = 1'b0;
    sweep("R6 same cycle");

    do_cmd(K_DIS); m_acc = 1'b0; m_lock = 1'b1;
    sweep("R8 disabled");
    unlock(z8);
    sweep("R8 unlock len0");
    do_cmd(K_DIS); m_acc = 1'b0; m_lock = 1'b1;
    unlock(z8);

    set_code(3, z8, ca, ca);
    m_acc = 1'b0; do_cmd(K_DIS); m_lock = 1'b1; unlock(z8);
    sweep("R3 R4 secure locked");

    sec_priv_ptr(10);
    check(ptr === 4'd6, "R7 ptr guarded", int'(ptr), 6);
    do_cmd(K_OVR);
    sweep("R7 ovr guarded");

    unlock(cbad);
    sweep("R12 wrong code");
    do_cmd(K_UNL); send_byte(8'hA1); send_byte(8'hB2);
    sweep("R12 partial");
    send_byte(8'hC3); m_acc = 1'b1; m_lock = 1'b0;
    sweep("R12 R3 unlocked");
    sweep("R9 all-array");

    sec_priv_ptr(10);
    check(ptr === 4'd10, "R7 R13 ptr moved", int'(ptr), 10);
    sweep("R3 new ptr");

    do_cmd(K_SET); send_byte(8'd2); send_byte(8'hA1); send_byte(8'hB2);
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
    send_byte(8'hC3); send_byte(8'h11);
    sweep("R11 R10 abort");
    do_cmd(K_SET); send_byte(8'd2); send_byte(8'hA1);
    do_cmd(K_PEON);
    send_byte(8'hB2); send_byte(8'hC3);
    sweep("R11 cmd abandons");

    set_code(2, ca, cb, cb2);
    sweep("R4 copy mismatch");
    set_code(2, cbad, cb, cb);
    sweep("R4 wrong old");
    set_code(9, ca, c8, c8);
    sweep("R5 illegal len");
    set_code(2, ca, cb, cb);
    check(m_len == 2, "R4 model", m_len, 2);
    sweep("R4 accepted");
    unlock(cb);
    sweep("R4 new code unlocks");

    do_cmd(K_DIS); m_acc = 1'b0; m_lock = 1'b1;
    sweep("R8 secure disabled");
    unlock(cb);
    set_code(8, cb, c8, c8);
    sweep("R4 len8");
    unlock(c8);
    set_code(0, c8, z8, z8);
    sweep("R5 len0 unprot");

    do_cmd(K_PEOFF); m_pe = 1'b0;
    sweep("R10 pe off");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule